// File: doc/BRIEF.md
# Trap Priority Arbiter with Nested Priority Level Tracking

This block chooses which non-maskable trap a processor core enters next and keeps track of the core's current priority level while trap handlers run. Up to eight trap request lines each map to a fixed priority level from 8 to 15. A request is recorded as pending. It is taken only at an instruction boundary, so the instruction that raised the condition finishes first. On entry the block reports the winning trap's index, raises the priority level to that trap's level and saves the previous level on a small stack. A return strobe restores the saved level.

Handlers may nest. A pending trap interrupts a running handler only if its level is strictly above the handler's level. When no handler runs, the software priority level has no effect on traps, even at 7 (all maskable interrupts off) or at 15. Two or more requests arriving in the same cycle, or an entry that would overflow the save stack, cannot be resolved. Either case raises a sticky lockout that stops all further trap entry until reset.

Top module: `trap_arbiter`

## Requirements
- R1: While and after reset, before any stimulus, `take_vld`, `lockout` and `in_trap` are 0, and `ipl_out` equals `sw_ipl`.
- R2: Bit i of `trap_req` is the trap of level 8+i. A single request is held pending and is taken only in the first cycle in which `instr_done` is 1. On the clock edge that ends that cycle, `take_vld` pulses for one cycle and `take_idx` is i.
- R3: When several traps became pending in different cycles, the one with the highest index is taken first. The others stay pending and are taken later, one entry per qualifying cycle.
- R4: While a handler runs (`in_trap` = 1), `ipl_out` equals 8 plus the index of the most recently entered trap, so bit 3 of `ipl_out` is 1.
- R5: With no handler running, a pending trap is taken whatever `sw_ipl` holds, including 4'b0111 and 4'b1111.
- R6: While a handler runs, a pending trap is taken only if its level is strictly greater than `ipl_out`. A trap at an equal or lower level waits until the handler returns.
- R7: A `trap_ret` pulse while `in_trap` is 1 restores the priority level in force before the latest entry. When no handler remains, `in_trap` is 0 and `ipl_out` follows `sw_ipl` again. A `trap_ret` pulse while `in_trap` is 0 has no effect.
- R8: If two or more `trap_req` bits are 1 in the same cycle, `lockout` becomes 1 on the next edge and stays 1 until reset. While `lockout` is 1, no trap is taken.
- R9: The save stack holds four levels. An entry attempted while four handlers are nested is not taken. It sets `lockout` instead and leaves `ipl_out` unchanged.
- R10: In a cycle where `trap_ret` and `instr_done` are both 1, only the return is performed and no trap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 8 | Trap request pulses; bit i is level 8+i |
| sw_ipl | input | 4 | Software-set priority level, used when no handler runs |
| instr_done | input | 1 | Current instruction has completed; a trap may be entered |
| trap_ret | input | 1 | Return-from-handler strobe |
| take_vld | output | 1 | One-cycle pulse: a trap has been entered |
| take_idx | output | 3 | Index of the entered trap (level minus 8) |
| ipl_out | output | 4 | Current priority level of the core |
| in_trap | output | 1 | At least one trap handler is active |
| lockout | output | 1 | Sticky unresolvable-trap indication |

## Verification
The ordering is exercised with single requests under software levels 7 and 15, and with three requests pending from separate cycles. These show whether arrival order or index decides the winner, and whether the software level wrongly masks a trap. Nesting sequences with an equal-level re-request, a strictly higher preemption and a return in the same cycle as `instr_done` separate the strict-greater rule and the return priority from looser comparisons. Two same-cycle requests and a fifth nested entry each target one of the two lockout causes. Each of these also checks that no vector escapes afterwards.

// File: rtl/trap_pkg.sv
// Package: shared types for the trap arbiter.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package trap_pkg;

    // Operation requested of the priority-level save stack in one cycle.
    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

endpackage

// File: rtl/trap_pending.sv
// Module: trap_pending
// Records incoming trap request pulses as pending bits and flags a cycle in
// which more than one request line is high at once.
// Assumes a request and a clear of the same bit never arrive in one cycle
// from a well-behaved source; if they do, the new request wins.
module trap_pending #(
    parameter int NUM_TRAPS = 8,
    localparam int IDX_W = (NUM_TRAPS > 1) ? $clog2(NUM_TRAPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TRAPS-1:0] req,
    input  logic                 clr_vld,
    input  logic [IDX_W-1:0]     clr_idx,
    output logic [NUM_TRAPS-1:0] pend,
    output logic                 multi_hit
);

    // One flop per trap line: set by a request, cleared when that trap is taken.
    for (genvar g = 0; g < NUM_TRAPS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[g] <= 1'b0;
            end else begin
                pend[g] <= req[g] | (pend[g] & ~(clr_vld && (clr_idx == IDX_W'(g))));
            end
        end
    end

    // Detect simultaneous arrival of two or more trap conditions.
    always_comb begin
        multi_hit = ($countones(req) > 1);
    end

endmodule

// File: rtl/trap_prio_enc.sv
// Module: trap_prio_enc
// Combinational fixed-priority encoder: finds the highest-indexed pending
// trap. Index order equals level order (level = base + index).
// Assumes the pending vector is registered upstream.
module trap_prio_enc #(
    parameter int NUM_TRAPS = 8,
    localparam int IDX_W = (NUM_TRAPS > 1) ? $clog2(NUM_TRAPS) : 1
) (
    input  logic [NUM_TRAPS-1:0] pend,
    output logic                 any,
    output logic [IDX_W-1:0]     top_idx
);

    // Scan upward so the highest set bit overwrites lower ones.
    always_comb begin
        any     = 1'b0;
        top_idx = '0;
        for (int i = 0; i < NUM_TRAPS; i++) begin
            if (pend[i]) begin
                any     = 1'b1;
                top_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ipl_stack.sv
// Module: ipl_stack
// Small LIFO holding priority levels saved on handler entry.
// Assumes the caller never pushes when full nor pops when empty; such
// requests are ignored here.
module ipl_stack
    import trap_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DATA_W = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_e           op,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] top_data,
    output logic              full,
    output logic              empty
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;

    // Status and pointer decode from the occupancy count.
    always_comb begin
        full     = (cnt == CNT_W'(DEPTH));
        empty    = (cnt == '0);
        wr_ptr   = ADDR_W'(cnt);
        rd_ptr   = ADDR_W'(cnt - CNT_W'(1));
        top_data = mem[rd_ptr];
    end

    // Occupancy counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (op == STK_PUSH && !full) begin
            cnt <= cnt + CNT_W'(1);
        end else if (op == STK_POP && !empty) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Storage entries, written at the next free slot on push.
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else if (op == STK_PUSH && !full && wr_ptr == ADDR_W'(e)) begin
                mem[e] <= push_data;
            end
        end
    end

endmodule

// File: rtl/trap_arbiter.sv
// Module: trap_arbiter (top)
// Arbitrates non-maskable trap requests against the current priority level,
// supports nesting with a save stack and raises a sticky lockout on
// simultaneous requests or save-stack overflow.
// Assumes instr_done marks an instruction boundary and trap_ret is a
// one-cycle strobe issued at the end of a handler.
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int NUM_TRAPS   = 8,
    parameter int IPL_W       = 4,
    parameter int LEVEL_BASE  = 8,
    parameter int STACK_DEPTH = 4,
    localparam int IDX_W = (NUM_TRAPS > 1) ? $clog2(NUM_TRAPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TRAPS-1:0] trap_req,
    input  logic [IPL_W-1:0]     sw_ipl,
    input  logic                 instr_done,
    input  logic                 trap_ret,
    output logic                 take_vld,
    output logic [IDX_W-1:0]     take_idx,
    output logic [IPL_W-1:0]     ipl_out,
    output logic                 in_trap,
    output logic                 lockout
);

    logic [NUM_TRAPS-1:0] pend;
    logic                 multi_hit;
    logic                 any_pend;
    logic [IDX_W-1:0]     cand_idx;
    logic [IPL_W-1:0]     cand_lvl;
    logic [IPL_W-1:0]     hdl_ipl;
    logic [IPL_W-1:0]     saved_ipl;
    logic                 stk_full;
    logic                 stk_empty;
    logic                 can_take;
    logic                 go;
    logic                 overflow;
    logic                 ret_go;
    logic                 lockout_q;
    stk_op_e              stk_op;

    trap_pending #(.NUM_TRAPS(NUM_TRAPS)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (trap_req),
        .clr_vld   (go),
        .clr_idx   (cand_idx),
        .pend      (pend),
        .multi_hit (multi_hit)
    );

    trap_prio_enc #(.NUM_TRAPS(NUM_TRAPS)) u_enc (
        .pend    (pend),
        .any     (any_pend),
        .top_idx (cand_idx)
    );

    ipl_stack #(.DEPTH(STACK_DEPTH), .DATA_W(IPL_W)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (stk_op),
        .push_data (ipl_out),
        .top_data  (saved_ipl),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    // Entry and return qualification for this cycle.
    always_comb begin
        in_trap  = !stk_empty;
        ipl_out  = in_trap ? hdl_ipl : sw_ipl;
        cand_lvl = IPL_W'(LEVEL_BASE) + IPL_W'(cand_idx);
        can_take = !lockout_q && instr_done && !trap_ret && any_pend &&
                   (!in_trap || (cand_lvl > hdl_ipl));
        go       = can_take && !stk_full;
        overflow = can_take && stk_full;
        ret_go   = trap_ret && in_trap;
        if (go) begin
            stk_op = STK_PUSH;
        end else if (ret_go) begin
            stk_op = STK_POP;
        end else begin
            stk_op = STK_HOLD;
        end
    end

    // Handler priority level: raised on entry, restored on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdl_ipl <= '0;
        end else if (go) begin
            hdl_ipl <= cand_lvl;
        end else if (ret_go) begin
            hdl_ipl <= saved_ipl;
        end
    end

    // Entry pulse and vector index output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_vld <= 1'b0;
            take_idx <= '0;
        end else begin
            take_vld <= go;
            if (go) begin
                take_idx <= cand_idx;
            end
        end
    end

    // Sticky lockout on unresolvable trap conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lockout_q <= 1'b0;
        end else if (multi_hit || overflow) begin
            lockout_q <= 1'b1;
        end
    end

    assign lockout = lockout_q;

endmodule

// File: rtl/trap_arbiter_chk.sv
// Module: trap_arbiter_chk
// Concurrent checks on the trap arbiter ports, attached by bind.
module trap_arbiter_chk #(
    parameter int NUM_TRAPS  = 8,
    parameter int IPL_W      = 4,
    parameter int LEVEL_BASE = 8,
    localparam int IDX_W = (NUM_TRAPS > 1) ? $clog2(NUM_TRAPS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_TRAPS-1:0] trap_req,
    input logic                 instr_done,
    input logic                 trap_ret,
    input logic                 take_vld,
    input logic [IDX_W-1:0]     take_idx,
    input logic [IPL_W-1:0]     ipl_out,
    input logic                 in_trap,
    input logic                 lockout
);

    // R4: bit 3 of the level is set whenever a handler runs.
    a_r4_trap_ipl_bit3: assert property (@(posedge clk) disable iff (!rst_n)
        in_trap |-> ipl_out[IPL_W-1]);

    // R4: after an entry the level equals the entered trap's level.
    a_r4_entry_level: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld |-> (ipl_out == IPL_W'(LEVEL_BASE) + IPL_W'(take_idx)));

    // R2: an entry follows a cycle with an instruction boundary.
    a_r2_take_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld |-> $past(instr_done));

    // R6: a nested entry strictly raises the level.
    a_r6_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (take_vld && $past(in_trap)) |-> (ipl_out > $past(ipl_out)));

    // R10: no entry on a return cycle.
    a_r10_ret_first: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld |-> !$past(trap_ret));

    // R8: simultaneous requests raise lockout.
    a_r8_multi_locks: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(trap_req) > 1) |=> lockout);

    // R8: lockout is sticky.
    a_r8_lockout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> lockout);

    // R8: no entry while locked out.
    a_r8_no_take_locked: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> !take_vld);

endmodule

bind trap_arbiter trap_arbiter_chk #(
    .NUM_TRAPS  (NUM_TRAPS),
    .IPL_W      (IPL_W),
    .LEVEL_BASE (LEVEL_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_req   (trap_req),
    .instr_done (instr_done),
    .trap_ret   (trap_ret),
    .take_vld   (take_vld),
    .take_idx   (take_idx),
    .ipl_out    (ipl_out),
    .in_trap    (in_trap),
    .lockout    (lockout)
);

// File: tb/trap_arbiter_tb.sv
// Bench: scoreboard of expected trap entries plus direct state checks.
module trap_arbiter_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] trap_req = '0;
    logic [3:0] sw_ipl = 4'd5;
    logic       instr_done = 1'b0;
    logic       trap_ret = 1'b0;
    logic       take_vld;
    logic [2:0] take_idx;
    logic [3:0] ipl_out;
    logic       in_trap;
    logic       lockout;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q[$];

    trap_arbiter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_req   (trap_req),
        .sw_ipl     (sw_ipl),
        .instr_done (instr_done),
        .trap_ret   (trap_ret),
        .take_vld   (take_vld),
        .take_idx   (take_idx),
        .ipl_out    (ipl_out),
        .in_trap    (in_trap),
        .lockout    (lockout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Generic check with requirement tag.
    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of inputs, return just after the edge.
    task automatic cyc(input logic [7:0] req, input logic done, input logic ret);
        @(negedge clk);
        trap_req   = req;
        instr_done = done;
        trap_ret   = ret;
        @(posedge clk);
        #1;
    endtask

    // Driver: expect an entry of index idx from the coming cycle.
    task automatic expect_take(input int idx);
        exp_q.push_back(idx);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        trap_req = '0; instr_done = 1'b0; trap_ret = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic queue_empty(input string tag);
        chk(tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // Monitor: every entry pulse must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && take_vld) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2/R3 unexpected entry: actual idx %0d expected none", take_idx);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(take_idx) != e) begin
                    n_bad++;
                    $display("FAIL R3 entry order: actual idx %0d expected %0d", take_idx, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        sw_ipl = 4'd5;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 take_vld", take_vld, 0);
        chk("R1 lockout", lockout, 0);
        chk("R1 in_trap", in_trap, 0);
        chk("R1 ipl_out", ipl_out, 5);
        do_reset();
        cyc(8'h00, 1'b0, 1'b0);
        chk("R1 ipl_out after reset", ipl_out, 5);

        // R2, R5: single trap under level 7, held until instr_done
        sw_ipl = 4'd7;
        cyc(8'h08, 1'b0, 1'b0);
        cyc(8'h00, 1'b0, 1'b0);
        cyc(8'h00, 1'b0, 1'b0);
        chk("R2 held until instr_done", take_vld, 0);
        chk("R2 no handler yet", in_trap, 0);
        expect_take(3);
        cyc(8'h00, 1'b1, 1'b0);
        chk("R5 taken at level 7", take_vld, 1);
        chk("R4 in_trap", in_trap, 1);
        chk("R4 level 11", ipl_out, 11);
        cyc(8'h00, 1'b0, 1'b1);
        chk("R7 return in_trap", in_trap, 0);
        chk("R7 follows sw_ipl", ipl_out, 7);
        cyc(8'h00, 1'b0, 1'b1);
        chk("R7 stray return in_trap", in_trap, 0);
        chk("R7 stray return level", ipl_out, 7);
        queue_empty("R2 queue drained");

        // R3, R5, R6: three pending from separate cycles under level 15
        sw_ipl = 4'd15;
        cyc(8'h02, 1'b0, 1'b0);
        cyc(8'h40, 1'b0, 1'b0);
        cyc(8'h10, 1'b0, 1'b0);
        expect_take(6);
        cyc(8'h00, 1'b1, 1'b0);
        chk("R5 taken at level 15", ipl_out, 14);
        cyc(8'h00, 1'b1, 1'b0);
        chk("R6 lower waits", take_vld, 0);
        chk("R6 level kept", ipl_out, 14);
        cyc(8'h00, 1'b0, 1'b1);
        chk("R7 back to sw", ipl_out, 15);
        expect_take(4);
        cyc(8'h00, 1'b1, 1'b0);
        chk("R3 second level", ipl_out, 12);
        cyc(8'h00, 1'b0, 1'b1);
        expect_take(1);
        cyc(8'h00, 1'b1, 1'b0);
        chk("R3 third level", ipl_out, 9);
        cyc(8'h00, 1'b0, 1'b1);
        queue_empty("R3 queue drained");

        // R6, R7, R10: nesting, equal level, return priority
        sw_ipl = 4'd3;
        cyc(8'h04, 1'b1, 1'b0);
        chk("R2 not same cycle as request", take_vld, 0);
        expect_take(2);
        cyc(8'h00, 1'b1, 1'b0);
        chk("R4 level 10", ipl_out, 10);
        cyc(8'h04, 1'b1, 1'b0);
        cyc(8'h00, 1'b1, 1'b0);
        chk("R6 equal level waits", take_vld, 0);
        chk("R6 equal level kept", ipl_out, 10);
        cyc(8'h20, 1'b0, 1'b0);
        expect_take(5);
        cyc(8'h00, 1'b1, 1'b0);
        chk("R6 higher preempts", ipl_out, 13);
        cyc(8'h80, 1'b0, 1'b0);
        cyc(8'h00, 1'b1, 1'b1);
        chk("R10 no entry on return", take_vld, 0);
        chk("R10 return done", ipl_out, 10);
        expect_take(7);
        cyc(8'h00, 1'b1, 1'b0);
        chk("R6 level 15 nested", ipl_out, 15);
        cyc(8'h00, 1'b0, 1'b1);
        chk("R7 restore 10", ipl_out, 10);
        cyc(8'h00, 1'b0, 1'b1);
        chk("R7 restore sw", ipl_out, 3);
        chk("R7 depth zero", in_trap, 0);
        expect_take(2);
        cyc(8'h00, 1'b1, 1'b0);
        chk("R6 waiting trap taken", ipl_out, 10);
        cyc(8'h00, 1'b0, 1'b1);
        queue_empty("R6 queue drained");

        // R9: fifth nested entry overflows
        sw_ipl = 4'd0;
        for (int k = 0; k < 4; k++) begin
            cyc(8'(1 << k), 1'b0, 1'b0);
            expect_take(k);
            cyc(8'h00, 1'b1, 1'b0);
        end
        chk("R9 four nested level", ipl_out, 11);
        cyc(8'h10, 1'b0, 1'b0);
        cyc(8'h00, 1'b1, 1'b0);
        chk("R9 no fifth entry", take_vld, 0);
        chk("R9 lockout", lockout, 1);
        chk("R9 level unchanged", ipl_out, 11);
        queue_empty("R9 queue drained");

        // R8: simultaneous requests
        do_reset();
        sw_ipl = 4'd2;
        cyc(8'h14, 1'b0, 1'b0);
        chk("R8 lockout set", lockout, 1);
        cyc(8'h00, 1'b1, 1'b0);
        cyc(8'h00, 1'b1, 1'b0);
        chk("R8 no entry", take_vld, 0);
        chk("R8 lockout sticky", lockout, 1);
        chk("R8 no handler", in_trap, 0);
        queue_empty("R8 queue drained");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule